// File: doc/BRIEF.md
# Serial Frame Alignment Inserter

This block is the transmit-side framer of a serial link. It emits one bit per clock. Each frame opens with a fixed alignment word that fills one contiguous slot, and payload bits taken from an upstream source fill the remaining positions. A receiver that hunts for the alignment word can then recover frame boundaries. The alignment word, its length and the total frame length are parameters. The defaults are the word `110100`, 6 bits long, in a 14-bit frame, which leaves 8 payload bits per frame.

The payload arrives on a valid/ready stream. The block raises `pl_ready` only in payload positions. A bit is taken in a cycle where `pl_ready` and `pl_valid` are both high, and it appears on `ser_out` in that same cycle. During the alignment slot the source is held back. If the source has nothing in a payload position, the block sends a 0 and keeps counting, so frame timing never depends on the source. `frame_start` marks the first alignment bit of every frame. Reset is synchronous and active high.

Top module: `sync_word_framer`

## Requirements
- R1: While `rst` is high, `pl_ready`, `frame_start` and `ser_out` are 0. In the first cycle after `rst` falls, `frame_start` is 1 and `ser_out` carries the first alignment bit.
- R2: In frame positions 0 to PAT_LEN-1, `ser_out` sends the alignment word most significant bit first. With the defaults, the bits in order are 1,1,0,1,0,0.
- R3: `pl_ready` is 0 in positions 0 to PAT_LEN-1 and 1 in positions PAT_LEN to FRAME_LEN-1 (6 to 13 by default).
- R4: In a payload position with `pl_valid` high, the bit is consumed and `ser_out` equals `pl_data` in that same cycle.
- R5: In a payload position with `pl_valid` low, `ser_out` is 0 and the frame position still advances.
- R6: `frame_start` is high for exactly one cycle per frame, and consecutive pulses are FRAME_LEN cycles apart when no reset comes between them.
- R7: During the alignment slot, `pl_valid` and `pl_data` have no effect on `ser_out`.
- R8: A reset asserted in the middle of a frame abandons that frame. The next frame starts at position 0 in the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pl_valid | input | 1 | Payload bit offered |
| pl_data | input | 1 | Payload bit value |
| pl_ready | output | 1 | Block will take a payload bit this cycle |
| ser_out | output | 1 | Serial line bit |
| frame_start | output | 1 | High with the first alignment bit of a frame |

## Verification
Two events can fall in the same clock edge, and these are the cases the bench provokes:
- **Frame wrap with a live payload bit.** The last payload position of a frame is consumed while the position counter wraps back to the alignment slot. The bench keeps `pl_valid` high across the wrap. It then checks that the last payload bit goes out, that `pl_ready` drops in the next cycle, and that the alignment word follows with no bit lost or repeated.
- **Reset during a payload handshake.** The bench raises reset in the middle of a frame while a handshake is under way. Outputs must go quiet, and the following frame must start at position 0.

Both cases are judged against a position model kept in the bench.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  typedef enum logic {
    SLOT_ALIGN = 1'b0,
    SLOT_DATA  = 1'b1
  } slot_e;
endpackage

// File: rtl/fsi_position_counter.sv
module fsi_position_counter
  import fsi_pkg::*;
#(
  parameter int FRAME_LEN = 14,
  parameter int PAT_LEN   = 6,
  localparam int CW       = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] pos,
  output slot_e         slot,
  output logic          at_first
);
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] DATA_POS = CW'(PAT_LEN);

  always_ff @(posedge clk) begin
    if (rst)                 pos <= '0;
    else if (pos == LAST_POS) pos <= '0;
    else                     pos <= pos + CW'(1);
  end

  always_comb begin
    slot     = (pos < DATA_POS) ? SLOT_ALIGN : SLOT_DATA;
    at_first = (pos == '0);
  end

  // R6: wrap after the last position
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (pos == LAST_POS) |=> (pos == '0));
  // R5: position always advances, whatever the payload source does
  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (pos != LAST_POS) |=> (pos == $past(pos) + CW'(1)));
endmodule

// File: rtl/fsi_align_word.sv
module fsi_align_word #(
  parameter int              PAT_LEN = 6,
  parameter logic [PAT_LEN-1:0] PATTERN = 6'b110100,
  parameter int              CW      = 4,
  localparam int             PW      = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1
) (
  input  logic [CW-1:0] pos,
  output logic          word_bit
);
  logic [PW-1:0] idx;
  always_comb begin
    idx      = PW'(PAT_LEN - 1) - pos[PW-1:0];
    word_bit = PATTERN[idx];
  end
endmodule

// File: rtl/fsi_payload_gate.sv
module fsi_payload_gate
  import fsi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_e slot,
  input  logic  word_bit,
  input  logic  pl_valid,
  input  logic  pl_data,
  output logic  pl_ready,
  output logic  line_bit
);
  logic take;
  always_comb begin
    pl_ready = !rst && (slot == SLOT_DATA);
    take     = pl_ready && pl_valid;
    if (rst)                    line_bit = 1'b0;
    else if (slot == SLOT_ALIGN) line_bit = word_bit;
    else                        line_bit = take ? pl_data : 1'b0;
  end

  // R3: the source is held back during the alignment slot
  a_r3_no_ready_in_align: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_ALIGN) |-> !pl_ready);
  // R5: an empty payload position sends a zero
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (pl_ready && !pl_valid) |-> !line_bit);
endmodule

// File: rtl/sync_word_framer.sv
module sync_word_framer
  import fsi_pkg::*;
#(
  parameter int                 FRAME_LEN = 14,
  parameter int                 PAT_LEN   = 6,
  parameter logic [PAT_LEN-1:0] PATTERN   = 6'b110100
) (
  input  logic clk,
  input  logic rst,
  input  logic pl_valid,
  input  logic pl_data,
  output logic pl_ready,
  output logic ser_out,
  output logic frame_start
);
  localparam int CW = $clog2(FRAME_LEN);

  if (FRAME_LEN <= PAT_LEN || PAT_LEN < 2) begin : g_bad_cfg
    $error("frame must be longer than a pattern of at least 2 bits");
  end

  logic [CW-1:0] pos;
  slot_e         slot;
  logic          at_first;
  logic          word_bit;

  fsi_position_counter #(.FRAME_LEN(FRAME_LEN), .PAT_LEN(PAT_LEN)) u_pos (
    .clk(clk), .rst(rst), .pos(pos), .slot(slot), .at_first(at_first));

  fsi_align_word #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .CW(CW)) u_word (
    .pos(pos), .word_bit(word_bit));

  fsi_payload_gate u_gate (
    .clk(clk), .rst(rst), .slot(slot), .word_bit(word_bit),
    .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .line_bit(ser_out));

  assign frame_start = at_first && !rst;

  // R1: quiet outputs while in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!pl_ready && !frame_start && !ser_out));
  // R1/R8: a frame opens right after reset is released
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (frame_start && ser_out == PATTERN[PAT_LEN-1]));
  // R6: strobe lasts a single cycle
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  // R3: strobe never coincides with a payload request
  a_r3_strobe_not_ready: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !pl_ready);
endmodule

// File: tb/tb_sync_word_framer.sv
`timescale 1ns/1ps
module tb_sync_word_framer;
  localparam int FL = 14;
  localparam int PL = 6;
  localparam logic [PL-1:0] PAT = 6'b110100;

  logic clk = 1'b0;
  logic rst, pl_valid, pl_data;
  logic pl_ready, ser_out, frame_start;

  int checks = 0, failures = 0;
  int mpos = 0;            // bench model of frame position
  int cyc = 0, last_fs = -1;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_word_framer #(.FRAME_LEN(FL), .PAT_LEN(PL), .PATTERN(PAT)) dut (
    .clk(clk), .rst(rst), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready), .ser_out(ser_out), .frame_start(frame_start));

  function automatic logic exp_ser(int p, logic r, logic v, logic d);
    if (r) return 1'b0;
    if (p < PL) return PAT[PL-1-p];
    return v ? d : 1'b0;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d pos=%0d actual=%b expected=%b", tag, cyc, mpos, act, exp);
    end
  endtask

  // drive at negedge, check shortly after, model advances at the next posedge
  task automatic step(logic r, logic v, logic d);
    @(negedge clk);
    rst = r; pl_valid = v; pl_data = d;
    #1;
    if (r) begin
      chk("R1 ready in reset", pl_ready, 1'b0);
      chk("R1 strobe in reset", frame_start, 1'b0);
      chk("R1 ser in reset", ser_out, 1'b0);
    end else begin
      chk("R3 ready", pl_ready, mpos >= PL);
      chk("R6 strobe", frame_start, mpos == 0);
      if (mpos < PL)      chk("R2/R7 align bit", ser_out, exp_ser(mpos, r, v, d));
      else if (v)         chk("R4 payload bit", ser_out, exp_ser(mpos, r, v, d));
      else                chk("R5 idle zero", ser_out, exp_ser(mpos, r, v, d));
      if (frame_start) begin
        if (last_fs >= 0) chk("R6 spacing", (cyc - last_fs) == FL, 1'b1);
        last_fs = cyc;
      end
    end
    if (r) begin mpos = 0; last_fs = -1; end
    else mpos = (mpos == FL - 1) ? 0 : mpos + 1;
    cyc++;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; pl_valid = 1'b0; pl_data = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);      // R1
    // R1/R8: first cycle after release is a frame start with pattern MSB
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 first strobe", frame_start, 1'b1);
    chk("R1 first bit", ser_out, PAT[PL-1]);
    @(posedge clk); mpos = 1; cyc++; last_fs = cyc - 1;
    // random payload traffic
    for (int i = 0; i < 20 * FL; i++)
      step(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    // R5: idle source for two frames
    for (int i = 0; i < 2 * FL; i++) step(1'b0, 1'b0, 1'b1);
    // R7: source pushes inverted pattern during the slot; R4 valid across wrap
    for (int i = 0; i < 3 * FL; i++)
      step(1'b0, 1'b1, (mpos < PL) ? ~PAT[PL-1-mpos] : 1'($urandom_range(0, 1)));
    // R8: reset in the middle of a payload handshake
    while (mpos != 9) step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 2 * FL; i++)
      step(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    chk("R8 model aligned", mpos == (2 * FL) % FL, 1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule